// File: doc/BRIEF.md
# Saturating doubling multiply-accumulate long lane unit

This block is the datapath of a packed-SIMD instruction that multiplies signed elements of two 64-bit operands, doubles each product, and folds it into a 128-bit accumulator whose lanes are twice the element width. Each lane saturates twice: once on the doubled product and once on the add or subtract into the accumulator lane. The unit supports both add and subtract, and the result is produced combinationally in the same cycle.

A second operand can be used element by element (vector form), or one element of it can be broadcast to every lane (scalar form). In scalar form the element is picked by an index whose encoding depends on the element size. The unit also checks the encoding and raises a flag if it is not legal. Any saturation in a defined, valid operation sets a sticky status flag, which only an explicit clear input resets. The instruction decoder upstream supplies the size code, the form and op selects, the index bits and the low bit of the destination register number. The register file supplies the operand values.

Top module: `sat_dmla_unit`

## Requirements
- R1: `size_i` = 2'b01 selects four 16-bit lanes, with result lane e in `res_o[32e+31:32e]`. `size_i` = 2'b10 selects two 32-bit lanes, with result lane e in `res_o[64e+63:64e]`. Element e of each source is bits `[w·e+w-1 : w·e]` for element width w.
- R2: `undef_o` is 1 when `size_i` is 2'b00 or 2'b11, or when `dst_lsb_i` is 1. It is 0 otherwise.
- R3: Each lane forms 2·a·b from the signed elements and saturates it to the double-width signed range. The only case that saturates is when both elements are the most negative value, and it yields the double-width maximum.
- R4: With `sub_i` = 0 the saturated product is added to the signed accumulator lane. With `sub_i` = 1 it is subtracted. The outcome is then saturated to the double-width signed range, in both the positive and the negative direction.
- R5: With `scalar_i` = 0, lane e uses element e of `opb_i`.
- R6: With `scalar_i` = 1 and 16-bit elements, every lane uses element {`sel_m_i`, `sel_hi_i`} of `opb_i` (index 0 to 3).
- R7: With `scalar_i` = 1 and 32-bit elements, every lane uses element `sel_m_i` of `opb_i`, and `sel_hi_i` has no effect.
- R8: If either saturation occurs in any lane of an operation with `op_valid_i` = 1 and `undef_o` = 0, `sat_o` is 1 from the next clock edge on.
- R9: `sat_o` stays 1 until a cycle with `clr_sat_i` = 1. If a clear and a saturation occur in the same cycle, the flag ends up set.
- R10: While `undef_o` = 1, `res_o` equals `acc_i` and the operation cannot set `sat_o`.
- R11: `sat_o` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| size_i | input | 2 | Element size code |
| sub_i | input | 1 | 1 = subtract product, 0 = add |
| scalar_i | input | 1 | Broadcast one element of opb_i |
| sel_m_i | input | 1 | Scalar index bit (high bit for 16-bit, sole bit for 32-bit) |
| sel_hi_i | input | 1 | Scalar index low bit for 16-bit elements |
| dst_lsb_i | input | 1 | Low bit of destination register number |
| clr_sat_i | input | 1 | Clear sticky saturation flag |
| opa_i | input | 64 | First source elements |
| opb_i | input | 64 | Second source elements |
| acc_i | input | 128 | Accumulator lanes |
| res_o | output | 128 | Result lanes |
| undef_o | output | 1 | Illegal encoding detected |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
Random operands drawn from a mix of zero, extreme and arbitrary elements exercise both element sizes, both op selects and both forms. A wide-integer model decides every lane. Directed minimum-times-minimum elements separate the product saturation from the accumulate saturation. Accumulators close to both limits, with add and with subtract, show that the second saturation clamps in the correct direction. Each scalar index value is given distinct operand elements, so a wrong element selection shows up in the result, and toggling the unused index bit in 32-bit mode shows that it has no effect. Illegal size codes and an odd destination, fed with saturating operands, show that the result passes the accumulator through and that the flag stays clear.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int VEC_W  = 64;
  localparam int ELEM_H = 16;
  localparam int ELEM_W = 32;
  localparam int N_H    = VEC_W / ELEM_H;
  localparam int N_W    = VEC_W / ELEM_W;
  localparam int ACC_W  = 2 * VEC_W;
  localparam int IDX_W  = $clog2(N_H);

  typedef enum logic [1:0] {
    SZ_RSV0 = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSV3 = 2'b11
  } esz_e;
endpackage

// File: rtl/sdm_sat.sv
// Clamp a W+1 bit signed value to W bits.
module sdm_sat #(
  parameter int W = 32
) (
  input  logic [W:0]   val_i,
  output logic [W-1:0] val_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  assign ovf_o = val_i[W] ^ val_i[W-1];
  assign val_o = ovf_o ? (val_i[W] ? MIN_V : MAX_V) : val_i[W-1:0];
endmodule

// File: rtl/sdm_lane.sv
module sdm_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0]   a_i,
  input  logic [EW-1:0]   b_i,
  input  logic [2*EW-1:0] acc_i,
  input  logic            sub_i,
  output logic [2*EW-1:0] res_o,
  output logic            sat_o
);
  localparam int AW = 2 * EW;

  logic signed [AW-1:0] a_x, b_x, prod;
  logic        [AW:0]   dbl, sum;
  logic        [AW-1:0] dprod;
  logic                 ovf_p, ovf_s;

  assign a_x  = {{EW{a_i[EW-1]}}, a_i};
  assign b_x  = {{EW{b_i[EW-1]}}, b_i};
  assign prod = a_x * b_x;
  assign dbl  = {prod, 1'b0};

  sdm_sat #(.W(AW)) u_sat_prod (.val_i(dbl), .val_o(dprod), .ovf_o(ovf_p));

  always_comb begin
    if (sub_i) sum = {acc_i[AW-1], acc_i} - {dprod[AW-1], dprod};
    else       sum = {acc_i[AW-1], acc_i} + {dprod[AW-1], dprod};
  end

  sdm_sat #(.W(AW)) u_sat_acc (.val_i(sum), .val_o(res_o), .ovf_o(ovf_s));

  assign sat_o = ovf_p | ovf_s;
endmodule

// File: rtl/sdm_decode.sv
module sdm_decode
  import sdm_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic             dst_lsb_i,
  input  logic             sel_m_i,
  input  logic             sel_hi_i,
  output logic             undef_o,
  output logic             half_o,
  output logic [IDX_W-1:0] idx_o
);
  esz_e sz;
  assign sz = esz_e'(size_i);

  always_comb begin
    undef_o = dst_lsb_i;
    half_o  = 1'b0;
    unique case (sz)
      SZ_HALF: half_o = 1'b1;
      SZ_WORD: half_o = 1'b0;
      default: undef_o = 1'b1;
    endcase
  end

  assign idx_o = half_o ? {sel_m_i, sel_hi_i} : {1'b0, sel_m_i};
endmodule

// File: rtl/sdm_sticky.sv
module sdm_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/sat_dmla_unit.sv
module sat_dmla_unit
  import sdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        size_i,
  input  logic              sub_i,
  input  logic              scalar_i,
  input  logic              sel_m_i,
  input  logic              sel_hi_i,
  input  logic              dst_lsb_i,
  input  logic              clr_sat_i,
  input  logic [VEC_W-1:0]  opa_i,
  input  logic [VEC_W-1:0]  opb_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [ACC_W-1:0]  res_o,
  output logic              undef_o,
  output logic              sat_o
);
  logic             half;
  logic [IDX_W-1:0] idx;

  sdm_decode u_dec (
    .size_i   (size_i),
    .dst_lsb_i(dst_lsb_i),
    .sel_m_i  (sel_m_i),
    .sel_hi_i (sel_hi_i),
    .undef_o  (undef_o),
    .half_o   (half),
    .idx_o    (idx)
  );

  // Lane views of the flat operands
  logic [N_H-1:0][ELEM_H-1:0]   opa_h, opb_h;
  logic [N_W-1:0][ELEM_W-1:0]   opa_w, opb_w;
  logic [N_H-1:0][2*ELEM_H-1:0] acc_h, res_h;
  logic [N_W-1:0][2*ELEM_W-1:0] acc_w, res_w;
  logic [N_H-1:0]               sat_h;
  logic [N_W-1:0]               sat_w;
  logic [ELEM_H-1:0]            bcast_h;
  logic [ELEM_W-1:0]            bcast_w;

  assign opa_h = opa_i;
  assign opb_h = opb_i;
  assign opa_w = opa_i;
  assign opb_w = opb_i;
  assign acc_h = acc_i;
  assign acc_w = acc_i;

  assign bcast_h = opb_h[idx];
  assign bcast_w = opb_w[idx[0]];

  for (genvar e = 0; e < N_H; e++) begin : g_half
    sdm_lane #(.EW(ELEM_H)) u_lane (
      .a_i  (opa_h[e]),
      .b_i  (scalar_i ? bcast_h : opb_h[e]),
      .acc_i(acc_h[e]),
      .sub_i(sub_i),
      .res_o(res_h[e]),
      .sat_o(sat_h[e])
    );
  end

  for (genvar e = 0; e < N_W; e++) begin : g_word
    sdm_lane #(.EW(ELEM_W)) u_lane (
      .a_i  (opa_w[e]),
      .b_i  (scalar_i ? bcast_w : opb_w[e]),
      .acc_i(acc_w[e]),
      .sub_i(sub_i),
      .res_o(res_w[e]),
      .sat_o(sat_w[e])
    );
  end

  logic sat_evt;
  assign sat_evt = op_valid_i & ~undef_o & (half ? |sat_h : |sat_w);

  always_comb begin
    if (undef_o)   res_o = acc_i;
    else if (half) res_o = res_h;
    else           res_o = res_w;
  end

  sdm_sticky u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sat_evt),
    .clr_i (clr_sat_i),
    .q_o   (sat_o)
  );
endmodule

// File: rtl/sdm_chk.sv
module sdm_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         op_valid_i,
  input logic [1:0]   size_i,
  input logic         scalar_i,
  input logic         dst_lsb_i,
  input logic         clr_sat_i,
  input logic [63:0]  opa_i,
  input logic [63:0]  opb_i,
  input logic [127:0] acc_i,
  input logic [127:0] res_o,
  input logic         undef_o,
  input logic         sat_o
);
  p_bad_size_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b00 || size_i == 2'b11 || dst_lsb_i) |-> undef_o);

  p_minmin_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && size_i == 2'b01 && !dst_lsb_i && !scalar_i &&
     opa_i[15:0] == 16'h8000 && opb_i[15:0] == 16'h8000) |=> sat_o);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !clr_sat_i) |=> sat_o);

  p_undef_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> res_o == acc_i);

  p_undef_noset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!sat_o || clr_sat_i) && (undef_o || !op_valid_i)) |=> !sat_o);
endmodule

bind sat_dmla_unit sdm_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_valid_i(op_valid_i),
  .size_i    (size_i),
  .scalar_i  (scalar_i),
  .dst_lsb_i (dst_lsb_i),
  .clr_sat_i (clr_sat_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .acc_i     (acc_i),
  .res_o     (res_o),
  .undef_o   (undef_o),
  .sat_o     (sat_o)
);

// File: tb/tb_sat_dmla_unit.sv
`timescale 1ns/1ps
module tb_sat_dmla_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid, sub, sc, m_b, hi_b, dl, clr;
  logic [1:0]   sz;
  logic [63:0]  a, b;
  logic [127:0] acc;
  logic [127:0] res;
  logic         undef, sat;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  bit  exp_sat = 0;

  always #2.5 clk = ~clk;

  sat_dmla_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .size_i(sz), .sub_i(sub),
    .scalar_i(sc), .sel_m_i(m_b), .sel_hi_i(hi_b), .dst_lsb_i(dl), .clr_sat_i(clr),
    .opa_i(a), .opb_i(b), .acc_i(acc), .res_o(res), .undef_o(undef), .sat_o(sat)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [71:0] clamp(input logic signed [71:0] v, input int w, inout bit s);
    logic signed [71:0] mx, mn;
    mx = (72'sd1 <<< (w - 1)) - 72'sd1;
    mn = -mx - 72'sd1;
    if (v > mx) begin s = 1; return mx; end
    if (v < mn) begin s = 1; return mn; end
    return v;
  endfunction

  function automatic logic [127:0] model(input logic [1:0] s_z, input logic sb, scl, hb, mb,
                                         input logic [63:0] x_v, y_v, input logic [127:0] ac,
                                         output bit st);
    logic signed [71:0] x, y, av, p, r;
    logic [127:0] out;
    int idx;
    bit s;
    s = 0;
    out = ac;
    if (s_z == 2'b01) begin
      idx = {30'd0, mb, hb};
      for (int e = 0; e < 4; e++) begin
        x  = $signed(x_v[16*e +: 16]);
        y  = scl ? $signed(y_v[16*idx +: 16]) : $signed(y_v[16*e +: 16]);
        av = $signed(ac[32*e +: 32]);
        p  = clamp(72'sd2 * x * y, 32, s);
        r  = clamp(sb ? av - p : av + p, 32, s);
        out[32*e +: 32] = r[31:0];
      end
    end else begin
      idx = {31'd0, mb};
      for (int e = 0; e < 2; e++) begin
        x  = $signed(x_v[32*e +: 32]);
        y  = scl ? $signed(y_v[32*idx +: 32]) : $signed(y_v[32*e +: 32]);
        av = $signed(ac[64*e +: 64]);
        p  = clamp(72'sd2 * x * y, 64, s);
        r  = clamp(sb ? av - p : av + p, 64, s);
        out[64*e +: 64] = r[63:0];
      end
    end
    st = s;
    return out;
  endfunction

  // Drive after a falling edge; result checked combinationally, flag after next rising edge.
  task automatic apply(input logic v, input logic [1:0] s_z, input logic sb, scl, hb, mb, d, c,
                       input logic [63:0] x_v, y_v, input logic [127:0] ac, input string tag);
    logic [127:0] e_res;
    bit e_und, st, setv;
    valid = v; sz = s_z; sub = sb; sc = scl; hi_b = hb; m_b = mb; dl = d; clr = c;
    a = x_v; b = y_v; acc = ac;
    #1;
    e_und = (s_z == 2'b00) || (s_z == 2'b11) || d;
    st = 0;
    e_res = e_und ? ac : model(s_z, sb, scl, hb, mb, x_v, y_v, ac, st);
    setv = v && !e_und && st;
    chk(res === e_res, {tag, " res"}, res, e_res);
    chk(undef === e_und, "R2 undef", {127'd0, undef}, {127'd0, e_und});
    @(posedge clk);
    if (setv) exp_sat = 1;
    else if (c) exp_sat = 0;
    @(negedge clk);
    chk(sat === exp_sat, {tag, " sat"}, {127'd0, sat}, {127'd0, exp_sat});
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom_range(0, 4))
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] pick32();
    case ($urandom_range(0, 4))
      0: return 32'h8000_0000;
      1: return 32'h7fff_ffff;
      2: return 32'h0000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0]  ra, rb;
    logic [127:0] racc;
    logic [1:0]   rsz;
    void'($urandom(32'd4242));
    rst_n = 0; valid = 0; sz = 2'b01; sub = 0; sc = 0; m_b = 0; hi_b = 0; dl = 0; clr = 0;
    a = '0; b = '0; acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sat === 1'b0, "R11 reset", {127'd0, sat}, 128'd0);
    rst_n = 1;
    @(negedge clk);

    // R1 R5 plain lanes, both sizes
    apply(1, 2'b01, 0, 0, 0, 0, 0, 0, 64'h0004_fffd_0003_0002, 64'h0005_0007_fffe_0010,
          128'h0000_0001_ffff_fff0_0000_0100_0000_0000, "R1");
    apply(1, 2'b10, 1, 0, 0, 0, 0, 0, 64'h1234_5678_ffff_fff0, 64'h0000_0100_0000_0003,
          128'h0000_0000_0000_1000_ffff_ffff_ffff_0000, "R5");

    // R3 product saturation, direct value
    apply(1, 2'b01, 0, 0, 0, 0, 0, 0, 64'h0001_0001_0001_8000, 64'h0001_0001_0001_8000, '0, "R3");
    chk(res[31:0] === 32'h7fff_ffff, "R3 lane0", {96'd0, res[31:0]}, 128'h7fff_ffff);
    apply(1, 2'b01, 0, 0, 0, 0, 0, 1, '0, '0, '0, "R9 clear");
    apply(1, 2'b10, 1, 0, 0, 0, 0, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, '0, "R3 word");
    chk(res[127:64] === 64'h8000_0000_0000_0001, "R3 word lane1", {64'd0, res[127:64]},
        128'h8000_0000_0000_0001);

    // R9 sticky and clear/set together
    apply(1, 2'b01, 0, 0, 0, 0, 0, 0, 64'h1, 64'h1, '0, "R9 hold");
    apply(1, 2'b01, 0, 0, 0, 0, 0, 1, 64'h8000, 64'h8000, '0, "R9 clr+set");
    apply(1, 2'b01, 0, 0, 0, 0, 0, 1, '0, '0, '0, "R9 clear");

    // R4 accumulate overflow both directions
    apply(1, 2'b01, 0, 0, 0, 0, 0, 0, 64'h0064, 64'h0064, 128'h7fff_fff0, "R4 pos");
    chk(res[31:0] === 32'h7fff_ffff, "R4 pos clamp", {96'd0, res[31:0]}, 128'h7fff_ffff);
    apply(1, 2'b01, 1, 0, 0, 0, 0, 1, 64'h0064, 64'h0064, 128'h8000_0010, "R4 neg");
    chk(res[31:0] === 32'h8000_0000, "R4 neg clamp", {96'd0, res[31:0]}, 128'h8000_0000);
    apply(1, 2'b10, 0, 0, 0, 0, 0, 1, 64'h7fff_ffff, 64'h7fff_ffff,
          128'h7000_0000_0000_0000, "R4 word");
    apply(1, 2'b01, 0, 0, 0, 0, 0, 1, '0, '0, '0, "R9 clear");

    // R6 every 16-bit scalar index; R7 every 32-bit index with unused bit toggled
    for (int i = 0; i < 4; i++)
      apply(1, 2'b01, i[0], 1, i[0], i[1], 0, 0, 64'h0004_0003_0002_0001,
            64'h0040_0030_0020_0010, 128'h0000_0100_0000_0200_0000_0300_0000_0400, "R6");
    for (int i = 0; i < 4; i++)
      apply(1, 2'b10, 0, 1, i[0], i[1], 0, 0, 64'h0000_0003_0000_0002,
            64'h0000_0700_0000_0500, 128'h0000_0000_0000_0001_0000_0000_0000_0002, "R7");

    // R10 illegal encodings with saturating operands
    apply(1, 2'b00, 0, 0, 0, 0, 0, 0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000,
          128'h0123_4567_89ab_cdef_0011_2233_4455_6677, "R10 size00");
    apply(1, 2'b11, 0, 0, 0, 0, 0, 0, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000,
          128'hfedc_ba98_7654_3210_0f0f_0f0f_f0f0_f0f0, "R10 size11");
    apply(1, 2'b01, 0, 0, 0, 0, 1, 0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000,
          128'h5555_aaaa_5555_aaaa_1234_1234_1234_1234, "R10 odd dst");
    apply(0, 2'b01, 0, 0, 0, 0, 0, 0, 64'h8000, 64'h8000, '0, "R8 invalid");

    // Random mix
    for (int k = 0; k < 800; k++) begin
      for (int j = 0; j < 4; j++) begin ra[16*j +: 16] = pick16(); rb[16*j +: 16] = pick16(); end
      for (int j = 0; j < 4; j++) racc[32*j +: 32] = pick32();
      if ($urandom_range(0, 3) == 0) begin
        ra = {pick32(), pick32()}; rb = {pick32(), pick32()};
      end
      rsz = ($urandom_range(0, 9) == 0) ? 2'(($urandom_range(0, 1)) * 3) : 2'($urandom_range(1, 2));
      apply($urandom_range(0, 9) != 0, rsz, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(0, 19) == 0, $urandom_range(0, 9) == 0, ra, rb, racc, "R8 rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule